// File: doc/BRIEF.md
# PFC Gate Pulse Sequencer

This block drives the gate of the switch in a boost power-factor-correction stage. It has an on-time command from an outer voltage loop, a demagnetisation (zero-current) input that is already qualified by a comparator, a cycle-by-cycle overcurrent flag, and two overvoltage flags at different bus levels. From these it produces a single gate output. All timing counts ticks of a prescaled clock. The default prescale turns a 50 MHz clock into 100 ns ticks.

After reset the sequencer runs open loop at a fixed off-time. The on-time starts small and grows by a fixed step each time a long interval of ticks ends. The first demagnetisation sample accepted during an off-time ends this start-up phase for good. From then on each pulse begins when demagnetisation ends (critical conduction), and the on-time command is clamped to a window. A command below the critical threshold puts the sequencer in discontinuous operation. In that mode the on-time may shrink to a lower floor, and a minimum off-time grows linearly as the command falls.

Two flags protect the stage. The high overvoltage flag stops gating. Gating then stays stopped until the lower flag drops. The overcurrent flag ends any pulse at once. The demagnetisation input is ignored for a short window after every gate edge, and a restart timeout fires a pulse if demagnetisation is never seen.

Top module: `pfc_gate_seq`

## Requirements
- R1: While reset is high, and for exactly START_OFF (default 400) ticks after reset is released, the gate output is low.
- R2: During start-up with no accepted demagnetisation sample, every off-time is START_OFF ticks. Each pulse lasts the current ramp value, and the first pulse is START_ON (default 10) ticks.
- R3: The start-up on-time grows by STEP_ON (default 10) ticks once every STEP_TICKS ticks. It never decreases and saturates at MAX_ON (default 230).
- R4: A demagnetisation sample accepted during a start-up off-time launches a pulse on the next tick and ends start-up permanently. That pulse already uses the clamped command.
- R5: After start-up, a command of at least CRIT_MIN (default 23) gives an on-time equal to the command clamped to at most MAX_ON. The gate rises one tick after the demagnetisation sample is accepted.
- R6: A command below CRIT_MIN gives an on-time clamped to at least MIN_ON (default 5). The pulse does not start before (CRIT_MIN - on-time) * SLOPE (default 8) ticks of off-time, and a sample accepted earlier is remembered.
- R7: After start-up, if no demagnetisation sample is accepted, a pulse is forced after minimum off-time + RESTART (default 400) ticks.
- R8: The demagnetisation input is ignored for BLANK (default 5) ticks starting at each gate edge. An input that is already high is accepted on the first tick after the window.
- R9: An overcurrent flag sampled high while the gate is high drives the gate low on the next clock.
- R10: The high overvoltage flag sets a block. The gate is low from the second clock after the flag is sampled, and no pulse starts while the block is set.
- R11: The block holds while the low overvoltage flag is high, even after the high flag drops. It clears on the clock that samples both flags low, and a pending demagnetisation sample then launches a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| on_cmd_i | input | 16 | Demanded on-time in ticks |
| zcd_i | input | 1 | Qualified demagnetisation-complete level |
| oc_i | input | 1 | Overcurrent comparator flag |
| ov_hi_i | input | 1 | Bus above the upper overvoltage level |
| ov_lo_i | input | 1 | Bus above the lower (release) overvoltage level |
| gate_o | output | 1 | Gate drive command |

## Verification
The bench runs with one tick per clock, so every result has a fixed latency in clocks. A demagnetisation sample accepted in off-cycle d makes the gate high in cycle d+1. An off-time therefore measures d+1, or BLANK+1 when d falls inside the window, or the stretch/timeout bound. Overcurrent sampled in high cycle k gives a pulse of k+1 cycles, and the high overvoltage flag gives k+2. After both overvoltage flags drop, the gate is high two clocks later. Inputs change and outputs are sampled only on falling edges, and every high or low cycle is counted at those edges, so each expected count comes straight from these latencies.

// File: rtl/pfc_seq_pkg.sv
package pfc_seq_pkg;

    localparam int unsigned PFC_TIME_W = 16;

    typedef logic [PFC_TIME_W-1:0] tick_t;

    typedef enum logic [1:0] {
        SEQ_STARTUP = 2'd0,
        SEQ_CRIT    = 2'd1,
        SEQ_DISC    = 2'd2
    } seq_mode_e;

    typedef enum logic {
        PH_OFF = 1'b0,
        PH_ON  = 1'b1
    } gate_phase_e;

    typedef struct packed {
        seq_mode_e mode;
        tick_t     on_len;
        tick_t     min_off;
    } pulse_plan_t;

    function automatic tick_t clamp_on(tick_t v, tick_t lo, tick_t hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    function automatic tick_t disc_stretch(tick_t on_len, tick_t crit_min, tick_t slope);
        if (on_len >= crit_min) return '0;
        return (crit_min - on_len) * slope;
    endfunction

    function automatic tick_t sat_step(tick_t v, tick_t inc, tick_t ceil);
        logic [PFC_TIME_W:0] sum;
        sum = {1'b0, v} + {1'b0, inc};
        if (sum >= {1'b0, ceil}) return ceil;
        return sum[PFC_TIME_W-1:0];
    endfunction

endpackage

// File: rtl/pfc_tick_gen.sv
module pfc_tick_gen #(
    parameter int unsigned DIV = 5
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV <= 1) begin : g_direct
            logic unused_ok;
            assign unused_ok = clk ^ rst;
            assign tick_o    = 1'b1;
        end else begin : g_div
            logic [CW-1:0] cnt_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    cnt_q <= '0;
                end else if (cnt_q == CW'(DIV - 1)) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
            assign tick_o = (cnt_q == CW'(DIV - 1));
        end
    endgenerate
endmodule

// File: rtl/pfc_startup_ramp.sv
module pfc_startup_ramp
    import pfc_seq_pkg::*;
#(
    parameter int unsigned START_ON   = 10,
    parameter int unsigned STEP_ON    = 10,
    parameter int unsigned MAX_ON     = 230,
    parameter int unsigned STEP_TICKS = 4000
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  tick_i,
    input  logic  active_i,
    output tick_t ramp_on_o
);
    localparam int unsigned SW = $clog2(STEP_TICKS + 1);
    localparam tick_t P_START = tick_t'(START_ON);
    localparam tick_t P_STEP  = tick_t'(STEP_ON);
    localparam tick_t P_MAX   = tick_t'(MAX_ON);

    logic [SW-1:0] step_cnt_q;
    tick_t         ramp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            step_cnt_q <= '0;
            ramp_q     <= P_START;
        end else if (tick_i && active_i) begin
            if (step_cnt_q == SW'(STEP_TICKS - 1)) begin
                step_cnt_q <= '0;
                ramp_q     <= sat_step(ramp_q, P_STEP, P_MAX);
            end else begin
                step_cnt_q <= step_cnt_q + 1'b1;
            end
        end
    end

    assign ramp_on_o = ramp_q;

    AST_RAMP_MONO: assert property (@(posedge clk) disable iff (rst)
        active_i |=> ramp_q >= $past(ramp_q)); // R3
    AST_RAMP_CEIL: assert property (@(posedge clk) disable iff (rst)
        ramp_q <= P_MAX); // R3
endmodule

// File: rtl/pfc_ovp_gate.sv
module pfc_ovp_gate (
    input  logic clk,
    input  logic rst,
    input  logic ov_hi_i,
    input  logic ov_lo_i,
    output logic block_o
);
    logic block_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            block_q <= 1'b0;
        end else if (ov_hi_i) begin
            block_q <= 1'b1;
        end else if (!ov_lo_i) begin
            block_q <= 1'b0;
        end
    end

    assign block_o = block_q;

    AST_OVP_SET: assert property (@(posedge clk) disable iff (rst)
        ov_hi_i |=> block_o); // R10
    AST_OVP_HOLD: assert property (@(posedge clk) disable iff (rst)
        block_o && ov_lo_i |=> block_o); // R11
    AST_OVP_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !ov_hi_i && !ov_lo_i |=> !block_o); // R11
endmodule

// File: rtl/pfc_zcd_qual.sv
module pfc_zcd_qual #(
    parameter int unsigned BLANK = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic gate_i,
    input  logic zcd_i,
    output logic zcd_ok_o
);
    localparam int unsigned BW = $clog2(BLANK + 1);

    logic          gate_q;
    logic [BW-1:0] blank_q;
    logic          edge_now;

    assign edge_now = gate_i ^ gate_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q  <= 1'b0;
            blank_q <= '0;
        end else begin
            gate_q <= gate_i;
            if (edge_now) begin
                blank_q <= BW'(BLANK - 1);
            end else if (tick_i && blank_q != '0) begin
                blank_q <= blank_q - 1'b1;
            end
        end
    end

    assign zcd_ok_o = zcd_i && !edge_now && (blank_q == '0);
endmodule

// File: rtl/pfc_gate_seq.sv
module pfc_gate_seq
    import pfc_seq_pkg::*;
#(
    parameter int unsigned TICK_DIV   = 5,
    parameter int unsigned START_ON   = 10,
    parameter int unsigned START_OFF  = 400,
    parameter int unsigned STEP_ON    = 10,
    parameter int unsigned STEP_TICKS = 4000,
    parameter int unsigned MIN_ON     = 5,
    parameter int unsigned CRIT_MIN   = 23,
    parameter int unsigned MAX_ON     = 230,
    parameter int unsigned BLANK      = 5,
    parameter int unsigned RESTART    = 400,
    parameter int unsigned SLOPE      = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [PFC_TIME_W-1:0] on_cmd_i,
    input  logic                  zcd_i,
    input  logic                  oc_i,
    input  logic                  ov_hi_i,
    input  logic                  ov_lo_i,
    output logic                  gate_o
);
    localparam tick_t P_START_OFF = tick_t'(START_OFF);
    localparam tick_t P_MIN_ON    = tick_t'(MIN_ON);
    localparam tick_t P_CRIT_MIN  = tick_t'(CRIT_MIN);
    localparam tick_t P_MAX_ON    = tick_t'(MAX_ON);
    localparam tick_t P_RESTART   = tick_t'(RESTART);
    localparam tick_t P_SLOPE     = tick_t'(SLOPE);
    localparam tick_t P_BLANK     = tick_t'(BLANK);

    logic        tick;
    tick_t       ramp_on;
    logic        ovp_block;
    logic        zcd_ok;

    gate_phase_e phase_q;
    logic        started_q;
    logic        seen_q;
    tick_t       timer_q;
    tick_t       on_len_q;

    pulse_plan_t plan;
    logic        launch_ready;
    logic        launch;
    logic        cut;
    tick_t       launch_len;

    pfc_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick)
    );

    pfc_startup_ramp #(
        .START_ON   (START_ON),
        .STEP_ON    (STEP_ON),
        .MAX_ON     (MAX_ON),
        .STEP_TICKS (STEP_TICKS)
    ) u_ramp (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick),
        .active_i  (!started_q),
        .ramp_on_o (ramp_on)
    );

    pfc_ovp_gate u_ovp (
        .clk     (clk),
        .rst     (rst),
        .ov_hi_i (ov_hi_i),
        .ov_lo_i (ov_lo_i),
        .block_o (ovp_block)
    );

    pfc_zcd_qual #(.BLANK(BLANK)) u_zcd (
        .clk      (clk),
        .rst      (rst),
        .tick_i   (tick),
        .gate_i   (gate_o),
        .zcd_i    (zcd_i),
        .zcd_ok_o (zcd_ok)
    );

    // Pulse plan from the present command and phase of operation
    always_comb begin
        plan.on_len = clamp_on(on_cmd_i, P_MIN_ON, P_MAX_ON);
        if (!started_q) begin
            plan.mode = SEQ_STARTUP;
        end else if (plan.on_len < P_CRIT_MIN) begin
            plan.mode = SEQ_DISC;
        end else begin
            plan.mode = SEQ_CRIT;
        end
        plan.min_off = (plan.mode == SEQ_DISC)
                     ? disc_stretch(plan.on_len, P_CRIT_MIN, P_SLOPE) : '0;
    end

    always_comb begin
        unique case (plan.mode)
            SEQ_STARTUP: launch_ready = zcd_ok || (timer_q >= P_START_OFF - 1'b1);
            default:     launch_ready = (timer_q >= plan.min_off) &&
                                        (seen_q || zcd_ok ||
                                         (timer_q >= plan.min_off + P_RESTART - 1'b1));
        endcase
        launch     = (phase_q == PH_OFF) && tick && !ovp_block && launch_ready;
        launch_len = (plan.mode == SEQ_STARTUP && !zcd_ok) ? ramp_on : plan.on_len;
        cut        = (phase_q == PH_ON) &&
                     (oc_i || ovp_block || (tick && timer_q >= on_len_q - 1'b1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_OFF;
            started_q <= 1'b0;
            seen_q    <= 1'b0;
            timer_q   <= '0;
            on_len_q  <= tick_t'(START_ON);
        end else begin
            unique case (phase_q)
                PH_ON: begin
                    if (cut) begin
                        phase_q <= PH_OFF;
                        timer_q <= '0;
                        seen_q  <= 1'b0;
                    end else if (tick) begin
                        timer_q <= timer_q + 1'b1;
                    end
                end
                default: begin
                    if (launch) begin
                        phase_q   <= PH_ON;
                        timer_q   <= '0;
                        on_len_q  <= launch_len;
                        started_q <= started_q | zcd_ok;
                        seen_q    <= 1'b0;
                    end else begin
                        if (tick && timer_q != '1) begin
                            timer_q <= timer_q + 1'b1;
                        end
                        if (zcd_ok) begin
                            seen_q <= 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    assign gate_o = (phase_q == PH_ON);

    AST_OC_CUT: assert property (@(posedge clk) disable iff (rst)
        oc_i && gate_o |=> !gate_o); // R9
    AST_OVP_BLOCK: assert property (@(posedge clk) disable iff (rst)
        ovp_block |=> !gate_o); // R10
    AST_ON_CEIL: assert property (@(posedge clk) disable iff (rst)
        gate_o |-> timer_q < P_MAX_ON); // R5
    AST_BLANK_GAP: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_o) && $past(started_q) |-> $past(timer_q) >= P_BLANK); // R8
    AST_START_STICKY: assert property (@(posedge clk) disable iff (rst)
        started_q |=> started_q); // R4
endmodule

// File: tb/test_pfc_gate_seq.sv
module test_pfc_gate_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] on_cmd = '0;
    logic        zcd = 1'b0;
    logic        oc = 1'b0;
    logic        ov_hi = 1'b0;
    logic        ov_lo = 1'b0;
    logic        gate;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    pfc_gate_seq #(
        .TICK_DIV   (1),
        .STEP_TICKS (500)
    ) i_pfc_gate_seq (
        .clk      (clk),
        .rst      (rst),
        .on_cmd_i (on_cmd),
        .zcd_i    (zcd),
        .oc_i     (oc),
        .ov_hi_i  (ov_hi),
        .ov_lo_i  (ov_lo),
        .gate_o   (gate)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; zcd = 0; oc = 0; ov_hi = 0; ov_lo = 0;
        repeat (4) @(negedge clk);
        chk("R1 gate low in reset", int'(gate), 0);
        rst = 1'b0;
    endtask

    // Called at a negedge in the first low cycle; returns low and high counts.
    // zd: low-cycle index where zcd goes high (-1 none); cut_at: high index for oc/ov cut.
    task automatic cycle_pulse(input int zd, input int cut_at, input bit cut_ov,
                               output int lo, output int hi);
        lo = 0;
        while (gate == 1'b0) begin
            if (zd >= 0 && lo == zd) zcd = 1'b1;
            lo++;
            @(negedge clk);
        end
        zcd = 1'b0;
        hi = 0;
        while (gate == 1'b1) begin
            if (hi == cut_at) begin
                if (cut_ov) begin ov_hi = 1'b1; ov_lo = 1'b1; end
                else oc = 1'b1;
            end
            hi++;
            @(negedge clk);
        end
        oc = 1'b0;
        ov_hi = 1'b0;
    endtask

    task automatic t_startup_ramp();
        int lo, hi, prev;
        do_reset();
        cycle_pulse(-1, -1, 0, lo, hi);
        chk("R1 first off-time", lo, 400);
        chk("R2 first start pulse width", hi, 10);
        prev = hi;
        for (int i = 0; i < 40; i++) begin
            cycle_pulse(-1, -1, 0, lo, hi);
            chk("R2 start-up off-time", lo, 400);
            chk("R3 width non-decreasing", int'(hi >= prev), 1);
            chk("R3 width on step grid", int'((hi % 10 == 0) && hi <= 230), 1);
            prev = hi;
        end
        chk("R3 ramp saturates at ceiling", hi, 230);
    endtask

    task automatic t_handover_crit();
        int lo, hi;
        on_cmd = 16'd50;
        do_reset();
        cycle_pulse(-1, -1, 0, lo, hi);
        chk("R2 start pulse before handover", hi, 10);
        cycle_pulse(20, -1, 0, lo, hi);
        chk("R4 handover off-time", lo, 21);
        chk("R4 handover uses command", hi, 50);
        cycle_pulse(30, -1, 0, lo, hi);
        chk("R5 crit off-time", lo, 31);
        chk("R5 crit on-time", hi, 50);
        on_cmd = 16'd300;
        cycle_pulse(10, -1, 0, lo, hi);
        chk("R5 on-time clamp high", hi, 230);
        on_cmd = 16'd23;
        cycle_pulse(8, -1, 0, lo, hi);
        chk("R5 crit threshold off-time", lo, 9);
        chk("R5 crit threshold on-time", hi, 23);
        cycle_pulse(2, -1, 0, lo, hi);
        chk("R8 zcd inside blanking", lo, 6);
        cycle_pulse(4, -1, 0, lo, hi);
        chk("R8 zcd at last blank cycle", lo, 6);
        cycle_pulse(5, -1, 0, lo, hi);
        chk("R8 zcd just after blanking", lo, 6);
        cycle_pulse(-1, -1, 0, lo, hi);
        chk("R7 crit restart timeout", lo, 400);
    endtask

    task automatic t_disc();
        int lo, hi;
        on_cmd = 16'd50;
        do_reset();
        cycle_pulse(-1, -1, 0, lo, hi);
        cycle_pulse(20, -1, 0, lo, hi);
        on_cmd = 16'd13;
        cycle_pulse(20, -1, 0, lo, hi);
        chk("R6 disc stretched off-time", lo, 81);
        chk("R6 disc on-time", hi, 13);
        on_cmd = 16'd2;
        cycle_pulse(20, -1, 0, lo, hi);
        chk("R6 disc off-time at floor", lo, 145);
        chk("R6 disc on-time floor", hi, 5);
        on_cmd = 16'd13;
        cycle_pulse(100, -1, 0, lo, hi);
        chk("R6 late zcd in disc", lo, 101);
        cycle_pulse(-1, -1, 0, lo, hi);
        chk("R7 disc restart timeout", lo, 480);
    endtask

    task automatic t_overcurrent();
        int lo, hi;
        on_cmd = 16'd100;
        do_reset();
        cycle_pulse(-1, -1, 0, lo, hi);
        cycle_pulse(20, 30, 0, lo, hi);
        chk("R9 oc cut mid pulse", hi, 31);
        cycle_pulse(20, 0, 0, lo, hi);
        chk("R9 oc at first high cycle", hi, 1);
        cycle_pulse(20, -1, 0, lo, hi);
        chk("R9 full pulse after oc clears", hi, 100);
    endtask

    task automatic t_overvoltage();
        int lo, hi, viol, k;
        on_cmd = 16'd50;
        do_reset();
        cycle_pulse(-1, -1, 0, lo, hi);
        cycle_pulse(20, 10, 1, lo, hi);
        chk("R10 ov cuts pulse", hi, 12);
        zcd = 1'b1;
        viol = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (gate) viol++;
        end
        chk("R11 block holds while low flag high", viol, 0);
        ov_lo = 1'b0;
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!gate && k < 6);
        chk("R11 gating resumes after release", k, 2);
        zcd = 1'b0;
        hi = 0;
        while (gate) begin hi++; @(negedge clk); end
        chk("R10 pulse width after release", hi, 50);
        ov_hi = 1'b1; ov_lo = 1'b1; zcd = 1'b1;
        @(negedge clk);
        ov_hi = 1'b0;
        viol = 0;
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            if (gate) viol++;
        end
        chk("R10 no pulse while blocked in off-time", viol, 0);
        ov_lo = 1'b0; zcd = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_startup_ramp();
        t_handover_crit();
        t_disc();
        t_overcurrent();
        t_overvoltage();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule